// File: doc/BRIEF.md
# Clock Ratio Detector and Resynchronizer

This block watches a system clock together with a left/right word clock taken from the same source and works out how many system clocks make up one sample period. It recognizes six legal ratios (128, 192, 256, 384, 512 and 768 system clocks per sample), reports the result as a three-bit code, and raises a locked flag once the measurement is trustworthy. Until lock is held, a force-to-midscale signal tells the downstream datapath to emit the bipolar-zero code.

After an active-low external reset or while a synchronous power-good input is low, the block holds its internal reset asserted. When both are released it runs a fixed initialization count before measurement begins. Once locked, it keeps a reference phase running at the locked ratio. Every new word-clock rising edge is compared against that phase. If the word clock drifts by more than six bit clocks, or stops, lock is dropped within one sample period and acquisition restarts. The word clock is treated as a level already synchronous to the system clock, and a frame is taken to hold 64 bit clocks.

Top module: `clk_ratio_detect`

## Requirements
- R1: While `rstN` is low the outputs read `intRstN`=0, `locked`=0, `forceMid`=1 and `ratioCode`=7.
- R2: With `powerGood` high, `intRstN` stays 0 for the first 1023 rising clock edges after `rstN` is released and reads 1 after the 1024th edge.
- R3: A low level on `powerGood` for one clock, or a low pulse on `rstN`, drives `intRstN` to 0 at once and restarts the full 1024-edge initialization from its release.
- R4: A word-clock period of N system clocks is classified as code 0 for 128, 1 for 192, 2 for 256, 3 for 384, 4 for 512 and 5 for 768, and any N within ±2 of one of these ratios counts as that ratio.
- R5: After initialization or a loss of lock, the first word-clock rising edge only starts a measurement, and lock is taken at the rising edge that ends the second consecutive period with the same code (the third rising edge). `locked` is still 0 after the second edge.
- R6: When `topRate` is 1, periods classified as 512 or 768 are invalid and never lock, and an existing lock at code 4 or 5 is dropped on the clock after `topRate` becomes 1. Ratios 128 to 384 still lock in that mode.
- R7: A period more than 2 away from every legal ratio leaves `locked`=0, `ratioCode`=7 and `forceMid`=1.
- R8: While locked at ratio R, the drift tolerance is T = 6·R/64 system clocks (12 at 128, 18 at 192). A rising edge whose accumulated offset from the locked phase is at most T early or late keeps lock. An edge outside that window drops lock at that edge.
- R9: While locked at ratio R, if no rising edge arrives, lock is dropped at the 141st edge for R=128 (R+T+1 edges after the last rising edge). It is still held 136 edges after it.
- R10: Whenever `locked` is 0, `forceMid` is 1 and `ratioCode` is 7. After a loss, the block locks again after two fresh matching measurements.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | External reset, active low, asynchronous assert |
| powerGood | input | 1 | Synchronous supply-valid indication; low restarts initialization |
| topRate | input | 1 | High when running in the highest sample-rate band |
| wordClk | input | 1 | Left/right word clock, synchronous to `clk` |
| ratioCode | output | 3 | Locked ratio code 0..5, 7 when not locked |
| locked | output | 1 | Ratio confirmed and word-clock phase within tolerance |
| intRstN | output | 1 | Internal reset for the datapath, active low |
| forceMid | output | 1 | Hold the datapath output at midscale |

## Verification
The assertions assume `wordClk` is a clean level that changes only away from the sampling edge, and that `topRate` stays steady for at least one clock before its effect on a lock is judged. The bench meets this by driving every input on the falling edge. Random trials pick a legal ratio and place each edge within ±1 clock of an ideal grid, so that period jitter stays inside the ±2 classification window and phase stays inside the drift window. Directed cases then push the period or phase past those limits on purpose.

// File: rtl/crd_pkg.sv
package crd_pkg;

  localparam int NUM_RATIOS = 6;
  localparam logic [2:0] CODE_INVALID = 3'd7;
  // first ratio index that is not allowed in the top sample-rate band
  localparam int TOP_RATE_LIMIT = 4;

  // ratio = base * multiplier, base 64 gives 128..768
  function automatic int ratioMult(input int idx);
    case (idx)
      0: return 2;
      1: return 3;
      2: return 4;
      3: return 6;
      4: return 8;
      default: return 12;
    endcase
  endfunction

  typedef struct packed {
    logic initRun;     // advance the initialization counter
    logic phaseAlign;  // restart reference phase at this edge
  } ctrl_strobe_t;

  typedef struct packed {
    logic       wcRise;
    logic       initDone;
    logic       measValid;
    logic [2:0] measCode;
    logic       inWindow;
    logic       timeout;
  } dp_status_t;

endpackage

// File: rtl/crd_classifier.sv
module crd_classifier
  import crd_pkg::*;
#(
  parameter int BASE_RATIO = 64,
  parameter int MATCH_TOL  = 2,
  parameter int CNT_W      = 11
) (
  input  logic [CNT_W-1:0] count,
  input  logic             topRate,
  output logic [2:0]       code,
  output logic             valid
);

  logic [31:0] cntWide;
  logic [NUM_RATIOS-1:0] hit;

  assign cntWide = {{(32-CNT_W){1'b0}}, count};

  for (genvar gi = 0; gi < NUM_RATIOS; gi++) begin : g_win
    localparam int RVAL = BASE_RATIO * ratioMult(gi);
    localparam logic [31:0] LO = 32'(RVAL - MATCH_TOL);
    localparam logic [31:0] HI = 32'(RVAL + MATCH_TOL);
    assign hit[gi] = (cntWide >= LO) && (cntWide <= HI);
  end

  always_comb begin
    code  = CODE_INVALID;
    valid = 1'b0;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if (hit[i] && !(topRate && (i >= TOP_RATE_LIMIT))) begin
        code  = 3'(i);
        valid = 1'b1;
      end
    end
  end

endmodule

// File: rtl/crd_datapath.sv
module crd_datapath
  import crd_pkg::*;
#(
  parameter int BASE_RATIO    = 64,
  parameter int INIT_CYCLES   = 1024,
  parameter int MATCH_TOL     = 2,
  parameter int DRIFT_BCK     = 6,
  parameter int BCK_PER_FRAME = 64,
  parameter int CNT_W         = 11,
  parameter int INIT_W        = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wordClk,
  input  logic         topRate,
  input  logic [2:0]   lockCode,
  input  ctrl_strobe_t strobe,
  output dp_status_t   status
);

  logic              wcPrev;
  logic              wcRise;
  logic [CNT_W-1:0]  sinceEdge;
  logic [CNT_W-1:0]  refPhase;
  logic [INIT_W-1:0] initCnt;
  logic [CNT_W-1:0]  lockRatio;
  logic [CNT_W-1:0]  lockTol;
  logic [2:0]        measCode;
  logic              measValid;

  assign wcRise = wordClk & ~wcPrev;

  always_comb begin
    lockRatio = CNT_W'(BASE_RATIO * ratioMult(int'(lockCode)));
    lockTol   = CNT_W'((DRIFT_BCK * BASE_RATIO * ratioMult(int'(lockCode))) / BCK_PER_FRAME);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wcPrev    <= 1'b0;
      sinceEdge <= '0;
      refPhase  <= '0;
      initCnt   <= '0;
    end else begin
      wcPrev <= wordClk;

      if (strobe.initRun) initCnt <= initCnt + 1'b1;
      else                initCnt <= '0;

      if (wcRise)                 sinceEdge <= CNT_W'(1);
      else if (sinceEdge != '1)   sinceEdge <= sinceEdge + 1'b1;

      if (strobe.phaseAlign)          refPhase <= CNT_W'(1);
      else if (refPhase >= lockRatio) refPhase <= CNT_W'(1);
      else                            refPhase <= refPhase + 1'b1;
    end
  end

  crd_classifier #(
    .BASE_RATIO(BASE_RATIO),
    .MATCH_TOL (MATCH_TOL),
    .CNT_W     (CNT_W)
  ) u_class (
    .count  (sinceEdge),
    .topRate(topRate),
    .code   (measCode),
    .valid  (measValid)
  );

  always_comb begin
    status.wcRise    = wcRise;
    status.initDone  = (initCnt == INIT_W'(INIT_CYCLES - 1));
    status.measValid = measValid;
    status.measCode  = measCode;
    // edge close to the expected wrap, early or late
    status.inWindow  = ((refPhase + lockTol) >= lockRatio) || (refPhase <= lockTol);
    status.timeout   = sinceEdge > (lockRatio + lockTol);
  end

endmodule

// File: rtl/crd_control.sv
module crd_control
  import crd_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         powerGood,
  input  logic         topRate,
  input  dp_status_t   status,
  output ctrl_strobe_t strobe,
  output logic [2:0]   ratioCode,
  output logic         locked,
  output logic         intRstN,
  output logic         forceMid
);

  typedef enum logic [1:0] {ST_INIT, ST_ACQ, ST_LOCK} state_e;

  state_e     stateQ;
  logic       haveRef;
  logic       candValid;
  logic [2:0] cand;
  logic [2:0] codeQ;
  logic       lockNow;
  logic       dropLock;

  assign lockNow = (stateQ == ST_ACQ) && status.wcRise && haveRef &&
                   status.measValid && candValid && (cand == status.measCode);

  assign dropLock = (stateQ == ST_LOCK) &&
                    ((status.wcRise && !status.inWindow) || status.timeout ||
                     (topRate && (codeQ >= 3'(TOP_RATE_LIMIT))));

  always_comb begin
    strobe.initRun    = (stateQ == ST_INIT) && powerGood;
    strobe.phaseAlign = lockNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_INIT;
      haveRef   <= 1'b0;
      candValid <= 1'b0;
      cand      <= '0;
      codeQ     <= CODE_INVALID;
    end else if (!powerGood) begin
      stateQ    <= ST_INIT;
      haveRef   <= 1'b0;
      candValid <= 1'b0;
      codeQ     <= CODE_INVALID;
    end else begin
      case (stateQ)
        ST_INIT: begin
          if (status.initDone) stateQ <= ST_ACQ;
        end
        ST_ACQ: begin
          if (status.wcRise) begin
            haveRef <= 1'b1;
            if (haveRef) begin
              if (lockNow) begin
                stateQ    <= ST_LOCK;
                codeQ     <= status.measCode;
                candValid <= 1'b0;
              end else if (status.measValid) begin
                cand      <= status.measCode;
                candValid <= 1'b1;
              end else begin
                candValid <= 1'b0;
              end
            end
          end
        end
        ST_LOCK: begin
          if (dropLock) begin
            stateQ  <= ST_ACQ;
            haveRef <= 1'b0;
            codeQ   <= CODE_INVALID;
          end
        end
        default: stateQ <= ST_INIT;
      endcase
    end
  end

  always_comb begin
    ratioCode = codeQ;
    locked    = (stateQ == ST_LOCK);
    intRstN   = (stateQ != ST_INIT);
    forceMid  = (stateQ != ST_LOCK);
  end

endmodule

// File: rtl/clk_ratio_detect.sv
module clk_ratio_detect
  import crd_pkg::*;
#(
  parameter int BASE_RATIO    = 64,
  parameter int INIT_CYCLES   = 1024,
  parameter int MATCH_TOL     = 2,
  parameter int DRIFT_BCK     = 6,
  parameter int BCK_PER_FRAME = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       powerGood,
  input  logic       topRate,
  input  logic       wordClk,
  output logic [2:0] ratioCode,
  output logic       locked,
  output logic       intRstN,
  output logic       forceMid
);

  localparam int MAX_RATIO = BASE_RATIO * ratioMult(NUM_RATIOS - 1);
  localparam int CNT_W     = $clog2(2 * MAX_RATIO + 1);
  localparam int INIT_W    = $clog2(INIT_CYCLES);

  ctrl_strobe_t strobe;
  dp_status_t   status;

  crd_datapath #(
    .BASE_RATIO   (BASE_RATIO),
    .INIT_CYCLES  (INIT_CYCLES),
    .MATCH_TOL    (MATCH_TOL),
    .DRIFT_BCK    (DRIFT_BCK),
    .BCK_PER_FRAME(BCK_PER_FRAME),
    .CNT_W        (CNT_W),
    .INIT_W       (INIT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .wordClk (wordClk),
    .topRate (topRate),
    .lockCode(ratioCode),
    .strobe  (strobe),
    .status  (status)
  );

  crd_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .powerGood(powerGood),
    .topRate  (topRate),
    .status   (status),
    .strobe   (strobe),
    .ratioCode(ratioCode),
    .locked   (locked),
    .intRstN  (intRstN),
    .forceMid (forceMid)
  );

endmodule

// File: rtl/crd_checker.sv
module crd_checker (
  input logic       clk,
  input logic       rstN,
  input logic       powerGood,
  input logic       topRate,
  input logic       wordClk,
  input logic [2:0] ratioCode,
  input logic       locked,
  input logic       intRstN,
  input logic       forceMid
);

  AST_PG_RESTARTS_INIT: assert property (@(posedge clk) disable iff (!rstN)
    !powerGood |=> !intRstN); // R3

  AST_LOCK_AFTER_INIT: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> intRstN); // R2

  AST_MIDSCALE_UNLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    !locked |-> (forceMid && ratioCode == 3'd7)); // R10

  AST_LOCK_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> ($past(wordClk) && !$past(wordClk, 2))); // R5

  AST_CODE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (locked && $past(locked)) |-> $stable(ratioCode)); // R4

  AST_TOP_RATE_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (locked && topRate && $past(topRate)) |-> (ratioCode < 3'd4)); // R6

endmodule

bind clk_ratio_detect crd_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .powerGood(powerGood),
  .topRate  (topRate),
  .wordClk  (wordClk),
  .ratioCode(ratioCode),
  .locked   (locked),
  .intRstN  (intRstN),
  .forceMid (forceMid)
);

// File: tb/clk_ratio_detect_tb.sv
module clk_ratio_detect_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       powerGood = 1'b1;
  logic       topRate = 1'b0;
  logic       wordClk = 1'b0;
  logic [2:0] ratioCode;
  logic       locked;
  logic       intRstN;
  logic       forceMid;

  int checks = 0;
  int fails  = 0;

  always #5ns clk = ~clk;

  clk_ratio_detect u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .powerGood(powerGood),
    .topRate  (topRate),
    .wordClk  (wordClk),
    .ratioCode(ratioCode),
    .locked   (locked),
    .intRstN  (intRstN),
    .forceMid (forceMid)
  );

  function automatic int ratioOf(input int idx);
    case (idx)
      0: return 128;
      1: return 192;
      2: return 256;
      3: return 384;
      4: return 512;
      default: return 768;
    endcase
  endfunction

  // expected classification of one period, from R4/R6/R7
  function automatic int expCode(input int per, input bit top);
    for (int i = 0; i < 6; i++) begin
      if (per >= ratioOf(i) - 2 && per <= ratioOf(i) + 2)
        return (top && i >= 4) ? 7 : i;
    end
    return 7;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input int per);
    for (int i = 0; i < per; i++) begin
      wordClk = (i < per / 2);
      @(negedge clk);
    end
  endtask

  task automatic frames(input int per, input int n);
    for (int k = 0; k < n; k++) frame(per);
  endtask

  task automatic chkLock(input string req, input int code);
    chk(req, int'(locked), 1);
    chk(req, int'(ratioCode), code);
    chk(req, int'(forceMid), 0);
  endtask

  task automatic chkUnlocked(input string req);
    chk(req, int'(locked), 0);
    chk(req, int'(ratioCode), 7);
    chk(req, int'(forceMid), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int prevE;
    void'($urandom(32'd4242));
    tick(3);
    // R1 reset state
    chk("R1 intRstN", int'(intRstN), 0);
    chkUnlocked("R1");
    rstN = 1'b1;
    tick(1023);
    chk("R2 init held", int'(intRstN), 0);
    tick(1);
    chk("R2 init done", int'(intRstN), 1);
    chkUnlocked("R10 after init");

    // R5 needs two matching measurements
    frames(128, 2);
    chkUnlocked("R5 two edges");
    frames(128, 1);
    chkLock("R5 third edge", 0);

    // R8 late drift accumulates: 5, 10 kept, 15 lost
    frame(133); frames(128, 2);
    chkLock("R8 late 5", 0);
    frame(133); frame(128);
    chkLock("R8 late 10", 0);
    frame(133); frame(128);
    chkUnlocked("R8 late 15");
    frames(128, 3);
    chkLock("R10 relock", 0);

    // R9 word clock stops
    wordClk = 1'b0;
    tick(9);
    chk("R9 still locked", int'(locked), 1);
    tick(6);
    chkUnlocked("R9 stopped");

    // R8 early side at 192 (tolerance 18)
    frames(192, 5);
    chkLock("R4 192", 1);
    frame(170); frame(192);
    chkUnlocked("R8 early 22");

    // R4 edges of the classification window
    frames(382, 5);
    chkLock("R4 384-2", expCode(382, 1'b0));
    frames(258, 5);
    chkLock("R4 256+2", expCode(258, 1'b0));

    // R7 out of window
    frames(125, 6);
    chkUnlocked("R7 125");
    frames(160, 5);
    chkUnlocked("R7 160");

    // R6 top rate band
    topRate = 1'b1;
    frames(512, 5);
    chkUnlocked("R6 512 top");
    frames(256, 4);
    chkLock("R6 256 top", 2);
    topRate = 1'b0;
    frames(512, 4);
    chkLock("R4 512", 4);
    topRate = 1'b1;
    tick(2);
    chkUnlocked("R6 drop on top");
    topRate = 1'b0;

    // R3 power-good glitch
    powerGood = 1'b0;
    tick(1);
    chk("R3 pg low", int'(intRstN), 0);
    chk("R3 pg low midscale", int'(forceMid), 1);
    powerGood = 1'b1;
    tick(1023);
    chk("R3 pg restart held", int'(intRstN), 0);
    tick(1);
    chk("R3 pg restart done", int'(intRstN), 1);

    // R3 external reset pulse
    frames(128, 4);
    chkLock("R4 128", 0);
    rstN = 1'b0;
    tick(1);
    chk("R3 rst low", int'(intRstN), 0);
    chkUnlocked("R1 in reset");
    rstN = 1'b1;
    tick(1023);
    chk("R3 rst restart held", int'(intRstN), 0);
    tick(1);
    chk("R3 rst restart done", int'(intRstN), 1);

    // random legal ratios with bounded edge jitter
    prevE = 0;
    for (int t = 0; t < 10; t++) begin
      int idx;
      idx = int'($urandom_range(0, 5));
      for (int f = 0; f < 7; f++) begin
        int e;
        e = int'($urandom_range(0, 2)) - 1;
        frame(ratioOf(idx) + e - prevE);
        prevE = e;
      end
      chkLock("R4 random", idx);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule